// File: doc/BRIEF.md
# Two-Context Paged MMU with Fixed Top Page

This unit sits between an 8-bit CPU with a 16-bit address bus and its memory. It splits the CPU address space into eight 8 KB logical blocks and translates each to one of up to 128 physical 8 KB blocks, giving a 20-bit physical address. Sixteen mapping entries are kept, split into two contexts of eight. One control bit chooses the live context, so software can switch between two complete address maps with a single store.

Software programs the unit through two write-only byte registers in the I/O window. The control register holds the enables, the context bit, an NMI trigger and an entry selector. The data register loads the selected entry. The unit also does four more things:
- It overlays the boot ROM on logical block 7 for reads.
- It always decodes a 16-byte I/O window at the top of the address space.
- It blocks writes to physical blocks marked as protected.
- It offers a latched mode that pins the top 512 bytes to physical block 7.

A store to the control register can also start a delayed NMI pulse. The pulse lets software interrupt the CPU after exactly one following instruction. The unit produces only the physical address and the chip-select and write-enable strobes. It drives no memory or device itself.

Top module: `paged_mmu`

## Requirements
- R1: With translation enabled, entry index = {context bit, addr[15:13]}. Physical address [19:13] = that entry's block number, and [12:0] = addr[12:0].
- R2: Reset clears ROM-disable, translation enable, the context bit and fixed-top mode. It does not clear the mapping entries. While translation is disabled, logical block n maps to physical block n, and no block is write-protected.
- R3: Context bit 0 uses entries 0–7. Context bit 1 uses entries 8–15.
- R4: The control register is a write to 0xFFDE. When bit 4 is 0, the write loads these fields:
  - bit 7: ROM disable
  - bit 6: context
  - bit 5: translation enable
  - bits 3:0: entry select

  A write to 0xFFDF loads the selected entry: bit 7 is write-protect, and bits 6:0 are the physical block number.
- R5: While ROM-disable is 0, reads in 0xE000–0xFFFF outside the I/O window assert rom_cs_o and not ram_cs_o. Writes there go to RAM.
- R6: Accesses in 0xFFD0–0xFFDF always assert io_cs_o. Reads there assert neither RAM nor ROM select. Writes there also assert ram_cs_o.
- R7: A write to a block whose entry has write-protect = 1 keeps ram_we_o low, and ram_cs_o still asserts.
- R8: Fixed-top mode is set only by a control write with bit 4 = 0, bit 7 = 0 and bit 5 = 1, made while ROM-disable = 1 and enable = 1. That write keeps ROM-disable at 1.
- R9: A control write with bit 4 = 0 and bit 5 = 0 clears fixed-top mode. Data writes and NMI writes leave it unchanged.
- R10: In fixed-top mode, accesses to 0xFE00–0xFFFF map to physical block 7 at the same 13-bit offset, whatever the table holds and whatever its write-protect says. This includes writes in the I/O window.
- R11: A control write with bit 4 = 1 leaves every other control field unchanged.
- R12: An NMI write sampled at clock edge k drives nmi_no low after edge k+NMI_DELAY and high again after edge k+NMI_DELAY+2. The default NMI_DELAY is 8.
- R13: fixed_top_o equals the fixed-top mode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock, one bus cycle per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | A bus cycle is in progress |
| bus_we_i | input | 1 | 1 for a write cycle |
| bus_addr_i | input | 16 | CPU logical address |
| bus_wdata_i | input | 8 | CPU write data |
| phys_addr_o | output | 20 | Translated physical address |
| ram_cs_o | output | 1 | RAM select |
| ram_we_o | output | 1 | RAM write enable |
| rom_cs_o | output | 1 | Boot ROM select |
| io_cs_o | output | 1 | I/O window select |
| nmi_no | output | 1 | Active-low NMI pulse |
| fixed_top_o | output | 1 | Fixed-top mode state, for debug |

## Verification
The assertions take two things for granted:
- Every entry reached by a live context has been loaded before translation is enabled. The table has no reset value.
- A new NMI request never arrives while an NMI pulse is still low.

The stimulus loads all sixteen entries while translation is still off. It also waits out each NMI pulse before issuing another trigger. Every cycle is compared against a behavioural model that tracks the register fields and the edge count of the last trigger.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;
  localparam int ADDR_W  = 16;
  localparam int LBLK_W  = 3;
  localparam int OFF_W   = ADDR_W - LBLK_W;
  localparam int PBLK_W  = 7;
  localparam int PADDR_W = PBLK_W + OFF_W;
  localparam int SEL_W   = LBLK_W + 1;
  localparam int N_ENT   = 1 << SEL_W;
  localparam int DATA_W  = 8;

  // control register bit positions (software visible)
  localparam int CB_ROMDIS = 7;
  localparam int CB_CTX    = 6;
  localparam int CB_EN     = 5;
  localparam int CB_NMI    = 4;
  // data register
  localparam int DB_WP     = 7;

  typedef struct packed {
    logic              wp;
    logic [PBLK_W-1:0] pbn;
  } map_ent_t;

  localparam int ENT_W = $bits(map_ent_t);

  typedef struct packed {
    logic             rom_dis;
    logic             ctx;
    logic             mmu_en;
    logic             fixed_top;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/pmmu_ctrl.sv
module pmmu_ctrl
  import pmmu_pkg::*;
#(
  parameter int NMI_DELAY = 8,
  parameter int NMI_WIDTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              nmi_no
);
  localparam int DLY_W = $clog2(NMI_DELAY + 1);
  localparam int PLS_W = $clog2(NMI_WIDTH + 1);

  ctrl_t ctrl_q;
  logic [DLY_W-1:0] dly_q;
  logic [PLS_W-1:0] pls_q;
  logic nmi_req;

  assign nmi_req = ctrl_we_i && wdata_i[CB_NMI];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i && !wdata_i[CB_NMI]) begin
      ctrl_q.ctx    <= wdata_i[CB_CTX];
      ctrl_q.mmu_en <= wdata_i[CB_EN];
      ctrl_q.sel    <= wdata_i[SEL_W-1:0];
      if (!wdata_i[CB_EN]) begin
        ctrl_q.fixed_top <= 1'b0;
        ctrl_q.rom_dis   <= wdata_i[CB_ROMDIS];
      end else if (ctrl_q.rom_dis && ctrl_q.mmu_en && !wdata_i[CB_ROMDIS]) begin
        // magic sequence: latch fixed top, keep ROM off
        ctrl_q.fixed_top <= 1'b1;
        ctrl_q.rom_dis   <= 1'b1;
      end else begin
        ctrl_q.rom_dis   <= wdata_i[CB_ROMDIS];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      pls_q <= '0;
    end else begin
      if (nmi_req)
        dly_q <= DLY_W'(NMI_DELAY);
      else if (dly_q != '0)
        dly_q <= dly_q - 1'b1;

      if (dly_q == DLY_W'(1) && !nmi_req)
        pls_q <= PLS_W'(NMI_WIDTH);
      else if (pls_q != '0)
        pls_q <= pls_q - 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign nmi_no = (pls_q == '0);

  a_r9_ft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[CB_NMI] && !wdata_i[CB_EN]) |=> !ctrl_q.fixed_top);

  a_r11_nmi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req |=> (ctrl_q == $past(ctrl_q)));

  a_r8_ft_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.fixed_top) |-> ($past(ctrl_q.rom_dis && ctrl_q.mmu_en) && ctrl_q.rom_dis));

  a_r12_pulse_low_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nmi_no) |=> !nmi_no);
endmodule

// File: rtl/pmmu_map.sv
module pmmu_map
  import pmmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  map_ent_t         wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output map_ent_t         rdata_o
);
  logic [N_ENT-1:0][ENT_W-1:0] flat;

  // entries carry no reset: software loads them before enabling
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    map_ent_t q;
    always_ff @(posedge clk_i) begin
      if (we_i && wsel_i == SEL_W'(g))
        q <= wdata_i;
    end
    assign flat[g] = q;
  end

  assign rdata_o = map_ent_t'(flat[rsel_i]);

  a_r4_entry_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (flat[$past(wsel_i)] == $past(wdata_i)));
endmodule

// File: rtl/pmmu_decode.sv
module pmmu_decode
  import pmmu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] IO_BASE    = 16'hFFD0,
  parameter int                IO_SPAN_W  = 4,
  parameter int                TOP_SPAN_W = 9,
  parameter int                TOP_BLK    = 7
) (
  input  logic               rom_dis_i,
  input  logic               ctx_i,
  input  logic               mmu_en_i,
  input  logic               fixed_top_i,
  input  logic               valid_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  map_ent_t           ent_i,
  output logic [SEL_W-1:0]   rsel_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               ram_cs_o,
  output logic               ram_we_o,
  output logic               rom_cs_o,
  output logic               io_cs_o
);
  logic [LBLK_W-1:0] blk;
  logic io_hit, top_hit, rom_hit, wp_eff;
  logic [PBLK_W-1:0] pbn;

  assign blk     = addr_i[ADDR_W-1:OFF_W];
  assign rsel_o  = {ctx_i, blk};
  assign io_hit  = addr_i[ADDR_W-1:IO_SPAN_W] == IO_BASE[ADDR_W-1:IO_SPAN_W];
  assign top_hit = fixed_top_i && (&addr_i[ADDR_W-1:TOP_SPAN_W]);

  always_comb begin
    if (top_hit) begin
      pbn    = PBLK_W'(TOP_BLK);
      wp_eff = 1'b0;
    end else if (mmu_en_i) begin
      pbn    = ent_i.pbn;
      wp_eff = ent_i.wp;
    end else begin
      pbn    = {{(PBLK_W-LBLK_W){1'b0}}, blk};
      wp_eff = 1'b0;
    end
  end

  assign rom_hit  = !rom_dis_i && (&blk) && !io_hit && !we_i;
  assign paddr_o  = {pbn, addr_i[OFF_W-1:0]};
  assign io_cs_o  = valid_i && io_hit;
  assign rom_cs_o = valid_i && rom_hit;
  assign ram_cs_o = valid_i && !rom_hit && !(io_hit && !we_i);
  assign ram_we_o = ram_cs_o && we_i && !wp_eff;
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import pmmu_pkg::*;
#(
  parameter int                NMI_DELAY = 8,
  parameter int                NMI_WIDTH = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFDE,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFDF,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hFFD0,
  parameter int                TOP_BLK   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [PADDR_W-1:0] phys_addr_o,
  output logic               ram_cs_o,
  output logic               ram_we_o,
  output logic               rom_cs_o,
  output logic               io_cs_o,
  output logic               nmi_no,
  output logic               fixed_top_o
);
  localparam int TOP_SPAN_W = 9;

  ctrl_t ctrl;
  map_ent_t ent_rd, ent_wr;
  logic [SEL_W-1:0] rsel;
  logic wr_cyc, ctrl_we, data_we;

  assign wr_cyc  = bus_valid_i && bus_we_i;
  assign ctrl_we = wr_cyc && bus_addr_i == CTRL_ADDR;
  assign data_we = wr_cyc && bus_addr_i == DATA_ADDR;
  assign ent_wr  = map_ent_t'({bus_wdata_i[DB_WP], bus_wdata_i[PBLK_W-1:0]});

  pmmu_ctrl #(.NMI_DELAY(NMI_DELAY), .NMI_WIDTH(NMI_WIDTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .wdata_i  (bus_wdata_i),
    .ctrl_o   (ctrl),
    .nmi_no   (nmi_no)
  );

  pmmu_map u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (data_we),
    .wsel_i (ctrl.sel),
    .wdata_i(ent_wr),
    .rsel_i (rsel),
    .rdata_o(ent_rd)
  );

  pmmu_decode #(
    .IO_BASE   (IO_BASE),
    .IO_SPAN_W (4),
    .TOP_SPAN_W(TOP_SPAN_W),
    .TOP_BLK   (TOP_BLK)
  ) u_dec (
    .rom_dis_i  (ctrl.rom_dis),
    .ctx_i      (ctrl.ctx),
    .mmu_en_i   (ctrl.mmu_en),
    .fixed_top_i(ctrl.fixed_top),
    .valid_i    (bus_valid_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .ent_i      (ent_rd),
    .rsel_o     (rsel),
    .paddr_o    (phys_addr_o),
    .ram_cs_o   (ram_cs_o),
    .ram_we_o   (ram_we_o),
    .rom_cs_o   (rom_cs_o),
    .io_cs_o    (io_cs_o)
  );

  assign fixed_top_o = ctrl.fixed_top;

  a_r10_top_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && fixed_top_o && (&bus_addr_i[ADDR_W-1:TOP_SPAN_W]))
      |-> (phys_addr_o[PADDR_W-1:OFF_W] == PBLK_W'(TOP_BLK)
           && phys_addr_o[OFF_W-1:0] == bus_addr_i[OFF_W-1:0]));

  a_r6_io_read_only_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_cs_o && !bus_we_i) |-> (!ram_cs_o && !rom_cs_o));

  a_r7_we_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (bus_we_i && ram_cs_o));

  a_r5_rom_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_cs_o |-> (!bus_we_i && !ram_cs_o && !io_cs_o));
endmodule

// File: tb/paged_mmu_tb_top.sv
module paged_mmu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 8;

  logic clk = 0, rst_ni = 0;
  logic valid = 0, we = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [19:0] paddr;
  logic ram_cs, ram_we, rom_cs, io_cs, nmi_n, ft;

  paged_mmu #(.NMI_DELAY(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .phys_addr_o(paddr),
    .ram_cs_o(ram_cs), .ram_we_o(ram_we), .rom_cs_o(rom_cs), .io_cs_o(io_cs),
    .nmi_no(nmi_n), .fixed_top_o(ft)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R2";

  // behavioural reference state
  bit m_romdis, m_ctx, m_en, m_ft;
  int m_sel;
  int m_pbn [16];
  bit m_wp [16];
  int k = 0;
  int nmi_k0 = -1000;

  task automatic chk(string t, logic [25:0] act, logic [25:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [25:0] expect_out();
    int blk, pb, idx;
    bit io, top, wp, rom, rcs, rwe;
    blk = int'(addr[15:13]);
    io  = (addr >= 16'hFFD0) && (addr <= 16'hFFDF);
    top = m_ft && (addr >= 16'hFE00);
    if (top) begin pb = 7; wp = 0; end
    else if (m_en) begin idx = (m_ctx ? 8 : 0) + blk; pb = m_pbn[idx]; wp = m_wp[idx]; end
    else begin pb = blk; wp = 0; end
    rom = valid && !m_romdis && blk == 7 && !io && !we;
    rcs = valid && !rom && !(io && !we);
    rwe = rcs && we && !wp;
    return {(valid ? {pb[6:0], addr[12:0]} : paddr), rcs, rwe, rom, valid && io,
            !((k - nmi_k0) >= DLY && (k - nmi_k0) < DLY + 2), m_ft};
  endfunction

  task automatic model_edge();
    k++;
    if (valid && we && addr == 16'hFFDE) begin
      if (wdata[4]) nmi_k0 = k;
      else begin
        m_ctx = wdata[6]; m_sel = int'(wdata[3:0]);
        if (!wdata[5]) begin m_ft = 0; m_romdis = wdata[7]; end
        else if (m_romdis && m_en && !wdata[7]) begin m_ft = 1; m_romdis = 1; end
        else m_romdis = wdata[7];
        m_en = wdata[5];
      end
    end else if (valid && we && addr == 16'hFFDF) begin
      m_pbn[m_sel] = int'(wdata[6:0]);
      m_wp[m_sel]  = wdata[7];
    end
  endtask

  // one bus cycle: drive after negedge, compare, take the edge
  task automatic cyc(bit v, bit w, logic [15:0] a, logic [7:0] d);
    valid = v; we = w; addr = a; wdata = d;
    #1;
    chk(tag, {paddr, ram_cs, ram_we, rom_cs, io_cs, nmi_n, ft}, expect_out());
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic rd(logic [15:0] a); cyc(1, 0, a, 8'h00); endtask
  task automatic wr(logic [15:0] a, logic [7:0] d); cyc(1, 1, a, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 16'h0000, 8'h00); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_romdis = 0; m_ctx = 0; m_en = 0; m_ft = 0; m_sel = 0;
    for (int i = 0; i < 16; i++) begin m_pbn[i] = 0; m_wp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;

    // R2 reset state and identity map
    tag = "R2";
    chk("R2 reset nmi/fixed", {24'h0, nmi_n, ft}, {24'h0, 1'b1, 1'b0});
    rd(16'h2345); rd(16'hC001); rd(16'h0000);
    tag = "R5"; rd(16'hE123); rd(16'hFFFE); wr(16'hE200, 8'h55);
    tag = "R6"; rd(16'hFFD5); wr(16'hFFD3, 8'hAA); rd(16'hFFCF);

    // R4 load all entries with translation off
    tag = "R4";
    for (int i = 0; i < 16; i++) begin
      wr(16'hFFDE, 8'(i));
      wr(16'hFFDF, {(i == 5) ? 1'b1 : 1'b0, 7'((i * 9 + 3) & 7'h7F)});
    end
    rd(16'h4000);

    // R1 translation in context 0
    tag = "R1";
    wr(16'hFFDE, 8'h20);
    for (int b = 0; b < 8; b++) rd(16'((b << 13) | 16'h0ABC));
    wr(16'h2001, 8'h01);
    tag = "R5"; rd(16'hF000); wr(16'hF000, 8'h12);
    tag = "R7"; wr(16'hA010, 8'h33); rd(16'hA010); wr(16'h8010, 8'h33);

    // R3 context 1
    tag = "R3";
    wr(16'hFFDE, 8'h60);
    for (int b = 0; b < 8; b++) rd(16'((b << 13) | 16'h1F00));
    wr(16'hA010, 8'h44);

    // R8 fixed-top entry conditions
    tag = "R8";
    wr(16'hFFDE, 8'h20);        // ROM still enabled: no latch
    rd(16'hFE10);
    wr(16'hFFDE, 8'hA0);        // ROM off, enable on, b7=1: no latch
    rd(16'hFE10);
    wr(16'hFFDE, 8'h20);        // magic write: latches, ROM stays off
    rd(16'hE400); rd(16'hFE10);

    // R10 fixed top overrides table and protect
    tag = "R10";
    wr(16'hFFDE, 8'hA7);        // select entry 7, keep mode
    wr(16'hFFDF, 8'h80 | 8'h2A); // protect entry 7
    rd(16'hFE10); wr(16'hFFF0, 8'h11); wr(16'hFE00, 8'h22);
    wr(16'hFFD1, 8'h33); rd(16'hFFD1); rd(16'hFFE0);
    tag = "R7"; wr(16'hFD00, 8'h44); wr(16'hE000, 8'h44);
    tag = "R13"; rd(16'hFDFF); rd(16'hFE00);

    // R9 other writes leave mode alone
    tag = "R9";
    wr(16'hFFDF, 8'h2A); rd(16'hFF00);
    wr(16'hFFDE, 8'hE7); rd(16'hFF00); rd(16'h6000);

    // R11 and R12: NMI write keeps context, pulse timing
    tag = "R11";
    wr(16'hFFDE, 8'h10); rd(16'h6000); rd(16'hFF80);
    tag = "R12"; idle(DLY + 4);
    tag = "R11";
    wr(16'hFFDE, 8'h1F); rd(16'h6000);
    tag = "R12"; for (int i = 0; i < DLY + 3; i++) rd(16'h2000);

    // R9 clear, back to identity
    tag = "R9";
    wr(16'hFFDE, 8'h80); rd(16'hFF00); rd(16'h6000);
    tag = "R2"; rd(16'hA010); wr(16'hA010, 8'h01);
    tag = "R5"; rd(16'hE000);
    tag = "R8"; wr(16'hFFDE, 8'h20); wr(16'hFFDE, 8'h20); rd(16'hFF00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule